// File: doc/BRIEF.md
# Two-Source Wake-Up Event Detector

This block runs while a device sleeps and decides when it should wake up. It watches two wake inputs. The first is the level from a bus receiver, where low is the dominant state. The second is a local wake switch that is active low. Each input first passes through a synchronizer. A separate filter per source then throws away short disturbances, and each accepted wake request appears on the output as a single-clock pulse.

A bus wake needs three things in order. The bus must fall, stay dominant for longer than the bus filter time, and then rise again. The pulse comes on that rising edge. A local wake fires while the switch is still held low, once the low level has lasted longer than the local filter time. After sleep is entered, or after a local request, the local input must be high for a minimum re-arm time before a new falling edge is accepted. Because of this, a switch that is already held down when sleep begins cannot raise a request.

The sleep-active enable is a synchronous, in-domain signal. While it is low, both detectors stay in their initial state with their timers cleared. All times are parameters counted in clock cycles. Here "synchronized cycles" means clock cycles of the input after the synchronizer.

Top module: `wake_detect_top`

## Requirements
- R1: A bus request needs a falling edge on the synchronized bus level while asleep, followed by more than BUS_FILT_CYC low synchronized cycles, followed by a rising edge. The pulse on `busWake` goes high two clock edges after the edge at which `busLvl` is first sampled high.
- R2: A bus low run of BUS_FILT_CYC synchronized cycles or fewer produces no request. The bus timer restarts on the next falling edge.
- R3: If the bus is already low when sleep becomes active, and there is no falling edge while asleep, no bus request is produced when the bus is released.
- R4: The bus timer saturates. A bus held low for any length longer than the filter produces exactly one request, on its rising edge.
- R5: A local request fires while `locLvl` is still low, after more than LOC_FILT_CYC low synchronized cycles. The pulse goes high LOC_FILT_CYC+2 clock edges after the edge that first samples `locLvl` low. Each low stretch gives at most one request.
- R6: A local low run of LOC_FILT_CYC synchronized cycles or fewer produces no request.
- R7: After sleep becomes active, and after each local request, `locLvl` must be high for more than LOC_REARM_CYC synchronized cycles before a falling edge is accepted. A low level present at sleep entry therefore raises no request.
- R8: While `sleepEn` is low, neither output pulses and both timers are cleared. A low run that is interrupted by leaving sleep does not count after sleep is entered again.
- R9: Each output is high for exactly one clock per request. A bus pulse and a local pulse may occur in the same cycle.
- R10: During reset (`rstN` low) both outputs are low, and the synchronizers hold the high (idle) level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepEn | input | 1 | High while the device sleeps; low clears both detectors |
| busLvl | input | 1 | Raw bus receiver level, low = dominant |
| locLvl | input | 1 | Raw local wake switch level, active low |
| busWake | output | 1 | One-cycle pulse on each accepted bus wake |
| locWake | output | 1 | One-cycle pulse on each accepted local wake |

## Verification
The bus pulse and the local pulse can fall in the same clock cycle, because the two filters run independently. The bench provokes this by releasing the bus after a qualifying dominant run at the moment the local switch's low run crosses its own filter. With the default bench filters, the local switch is pressed five cycles after the bus falls. It then checks that each output pulsed once and that both pulses carry the same cycle stamp. The counts and latencies are set against the filter lengths at their boundaries and one cycle beyond.

// File: rtl/wake_detect_pkg.sv
`timescale 1ns/1ps
package wake_detect_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic busLoad;
    logic busInc;
    logic busClr;
    logic busFire;
    logic locLoad;
    logic locInc;
    logic locClr;
    logic locFire;
  } wake_strobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic busLow;
    logic busFall;
    logic busFull;
    logic locLow;
    logic locFall;
    logic locFull;
    logic locRearmed;
  } wake_flag_t;

  typedef enum logic [0:0] {BUS_IDLE, BUS_LOW} bus_state_t;
  typedef enum logic [1:0] {LOC_BLOCK, LOC_IDLE, LOC_LOW} loc_state_t;

endpackage

// File: rtl/wake_sync.sv
`timescale 1ns/1ps
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_detect_dp.sv
`timescale 1ns/1ps
module wake_detect_dp
  import wake_detect_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BUS_FILT_CYC  = 10000,
  parameter int LOC_FILT_CYC  = 10000,
  parameter int LOC_REARM_CYC = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busLvl,
  input  logic         locLvl,
  input  wake_strobe_t strobe,
  output wake_flag_t   flag,
  output logic         busWake,
  output logic         locWake
);
  localparam int BUS_SAT_I = BUS_FILT_CYC + 1;
  localparam int BUS_W     = $clog2(BUS_SAT_I + 1);
  localparam int LOC_SAT_I = (LOC_FILT_CYC > LOC_REARM_CYC) ? LOC_FILT_CYC : LOC_REARM_CYC;
  localparam int LOC_W     = $clog2(LOC_SAT_I + 1);
  localparam logic [BUS_W-1:0] BUS_SAT   = BUS_W'(BUS_SAT_I);
  localparam logic [LOC_W-1:0] LOC_SAT   = LOC_W'(LOC_SAT_I);
  localparam logic [LOC_W-1:0] LOC_FILT  = LOC_W'(LOC_FILT_CYC);
  localparam logic [LOC_W-1:0] LOC_REARM = LOC_W'(LOC_REARM_CYC);

  logic [1:0] rawIn, syncIn;
  logic busPrev, locPrev;
  logic [BUS_W-1:0] busCnt;
  logic [LOC_W-1:0] locCnt;

  assign rawIn = {locLvl, busLvl};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    wake_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncIn[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPrev <= 1'b1;
      locPrev <= 1'b1;
    end else begin
      busPrev <= syncIn[0];
      locPrev <= syncIn[1];
    end
  end

  // bus dominant timer, saturating one past the filter length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busCnt <= '0;
    else if (strobe.busLoad)  busCnt <= BUS_W'(1);
    else if (strobe.busClr)   busCnt <= '0;
    else if (strobe.busInc && busCnt != BUS_SAT) busCnt <= busCnt + 1'b1;
  end

  // local timer, shared by the low filter and the re-arm window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                locCnt <= '0;
    else if (strobe.locLoad)  locCnt <= LOC_W'(1);
    else if (strobe.locClr)   locCnt <= '0;
    else if (strobe.locInc && locCnt != LOC_SAT) locCnt <= locCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busWake <= 1'b0;
      locWake <= 1'b0;
    end else begin
      busWake <= strobe.busFire;
      locWake <= strobe.locFire;
    end
  end

  always_comb begin
    flag.busLow     = !syncIn[0];
    flag.busFall    = busPrev && !syncIn[0];
    flag.busFull    = (busCnt == BUS_SAT);
    flag.locLow     = !syncIn[1];
    flag.locFall    = locPrev && !syncIn[1];
    flag.locFull    = (locCnt >= LOC_FILT);
    flag.locRearmed = (locCnt >= LOC_REARM);
  end
endmodule

// File: rtl/wake_detect_ctrl.sv
`timescale 1ns/1ps
module wake_detect_ctrl
  import wake_detect_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepEn,
  input  wake_flag_t   flag,
  output wake_strobe_t strobe
);
  bus_state_t busSt, busNx;
  loc_state_t locSt, locNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busSt <= BUS_IDLE;
      locSt <= LOC_BLOCK;
    end else if (!sleepEn) begin
      busSt <= BUS_IDLE;
      locSt <= LOC_BLOCK;
    end else begin
      busSt <= busNx;
      locSt <= locNx;
    end
  end

  always_comb begin
    strobe = '0;
    busNx  = busSt;
    locNx  = locSt;
    if (!sleepEn) begin
      strobe.busClr = 1'b1;
      strobe.locClr = 1'b1;
    end else begin
      unique case (busSt)
        BUS_IDLE: begin
          strobe.busClr = 1'b1;
          if (flag.busFall) begin
            strobe.busLoad = 1'b1;
            busNx          = BUS_LOW;
          end
        end
        BUS_LOW: begin
          if (flag.busLow) begin
            strobe.busInc = 1'b1;
          end else begin
            strobe.busFire = flag.busFull;
            strobe.busClr  = 1'b1;
            busNx          = BUS_IDLE;
          end
        end
        default: busNx = BUS_IDLE;
      endcase

      unique case (locSt)
        LOC_BLOCK: begin
          if (flag.locLow) begin
            strobe.locClr = 1'b1;
          end else if (flag.locRearmed) begin
            strobe.locClr = 1'b1;
            locNx         = LOC_IDLE;
          end else begin
            strobe.locInc = 1'b1;
          end
        end
        LOC_IDLE: begin
          strobe.locClr = 1'b1;
          if (flag.locFall) begin
            strobe.locLoad = 1'b1;
            locNx          = LOC_LOW;
          end
        end
        LOC_LOW: begin
          if (!flag.locLow) begin
            strobe.locClr = 1'b1;
            locNx         = LOC_IDLE;
          end else if (flag.locFull) begin
            strobe.locFire = 1'b1;
            strobe.locClr  = 1'b1;
            locNx          = LOC_BLOCK;
          end else begin
            strobe.locInc = 1'b1;
          end
        end
        default: locNx = LOC_BLOCK;
      endcase
    end
  end
endmodule

// File: rtl/wake_detect_top.sv
`timescale 1ns/1ps
module wake_detect_top
  import wake_detect_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BUS_FILT_CYC  = 10000,
  parameter int LOC_FILT_CYC  = 10000,
  parameter int LOC_REARM_CYC = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepEn,
  input  logic busLvl,
  input  logic locLvl,
  output logic busWake,
  output logic locWake
);
  wake_strobe_t strobe;
  wake_flag_t   flag;

  wake_detect_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sleepEn(sleepEn),
    .flag   (flag),
    .strobe (strobe)
  );

  wake_detect_dp #(
    .SYNC_STAGES  (SYNC_STAGES),
    .BUS_FILT_CYC (BUS_FILT_CYC),
    .LOC_FILT_CYC (LOC_FILT_CYC),
    .LOC_REARM_CYC(LOC_REARM_CYC)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .busLvl (busLvl),
    .locLvl (locLvl),
    .strobe (strobe),
    .flag   (flag),
    .busWake(busWake),
    .locWake(locWake)
  );
endmodule

// File: rtl/wake_detect_chk.sv
`timescale 1ns/1ps
module wake_detect_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic sleepEn,
  input logic busLvl,
  input logic locLvl,
  input logic busWake,
  input logic locWake
);
  localparam int LAG = SYNC_STAGES + 1;

  // R9: single-cycle pulses
  a_r9_bus_single: assert property (@(posedge clk) disable iff (!rstN)
    busWake |=> !busWake);
  a_r9_loc_single: assert property (@(posedge clk) disable iff (!rstN)
    locWake |=> !locWake);

  // R8: nothing while awake
  a_r8_quiet_awake: assert property (@(posedge clk) disable iff (!rstN)
    !sleepEn |=> (!busWake && !locWake));

  // R1: a bus pulse follows a sampled high bus level
  a_r1_bus_on_release: assert property (@(posedge clk) disable iff (!rstN)
    busWake |-> $past(busLvl, LAG));

  // R5: a local pulse fires while the switch is still low
  a_r5_loc_while_low: assert property (@(posedge clk) disable iff (!rstN)
    locWake |-> !$past(locLvl, LAG));

  // R10: outputs quiet in reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!busWake && !locWake));
endmodule

bind wake_detect_top wake_detect_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .sleepEn(sleepEn),
  .busLvl (busLvl),
  .locLvl (locLvl),
  .busWake(busWake),
  .locWake(locWake)
);

// File: tb/wake_detect_top_tb_top.sv
`timescale 1ns/1ps
module wake_detect_top_tb_top;
  localparam int BF = 20;
  localparam int LF = 16;
  localparam int LR = 4;
  localparam int NV = 10;

  // busLen, locLen, locDelay, expBus, expLoc
  localparam int VEC [NV][5] = '{
    '{BF+1, 0,    0, 1, 0},   // R1 just over filter
    '{BF,   0,    0, 0, 0},   // R2 at filter boundary
    '{5,    0,    0, 0, 0},   // R2 short glitch
    '{300,  0,    0, 1, 0},   // R4 long hold
    '{0,    LF+1, 0, 0, 1},   // R5 just over filter
    '{0,    LF,   0, 0, 0},   // R6 at boundary
    '{0,    3,    0, 0, 0},   // R6 short press
    '{0,    200,  0, 0, 1},   // R5 one per stretch
    '{40,   40,   0, 1, 1},   // R9 both sources
    '{BF+1, LF+1, 30, 1, 1}   // R9 staggered
  };
  string vtag [NV] = '{"R1", "R2", "R2", "R4", "R5", "R6", "R6", "R5", "R9", "R9"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepEn = 1'b0;
  logic busLvl = 1'b1;
  logic locLvl = 1'b1;
  logic busWake, locWake;

  always #2.5 clk = ~clk;

  wake_detect_top #(
    .SYNC_STAGES  (2),
    .BUS_FILT_CYC (BF),
    .LOC_FILT_CYC (LF),
    .LOC_REARM_CYC(LR)
  ) dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .sleepEn(sleepEn),
    .busLvl (busLvl),
    .locLvl (locLvl),
    .busWake(busWake),
    .locWake(locWake)
  );

  int cyc = 0;
  int busTot = 0, locTot = 0, busAt = 0, locAt = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (busWake) begin busTot++; busAt = cyc; end
    if (locWake) begin locTot++; locAt = cyc; end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterSleep();
    sleepEn = 1'b0;
    tick(3);
    sleepEn = 1'b1;
  endtask

  task automatic applyVec(input int bl, input int ll, input int ld,
                          output int nb, output int nl);
    int b0, l0, len;
    b0 = busTot; l0 = locTot;
    busLvl = 1'b1; locLvl = 1'b1;
    enterSleep();
    tick(LR + 6);
    len = ((bl > ld + ll) ? bl : ld + ll) + 2;
    for (int c = 0; c < len; c++) begin
      busLvl = !(c < bl);
      locLvl = !(c >= ld && c < ld + ll);
      tick(1);
    end
    busLvl = 1'b1; locLvl = 1'b1;
    tick(12);
    nb = busTot - b0;
    nl = locTot - l0;
  endtask

  initial begin
    int nb, nl, b0, l0, c0, cb;
    tick(3);
    // R10: reset state
    check("R10 busWake in reset", int'(busWake), 0);
    check("R10 locWake in reset", int'(locWake), 0);
    rstN = 1'b1;
    tick(3);

    for (int v = 0; v < NV; v++) begin
      applyVec(VEC[v][0], VEC[v][1], VEC[v][2], nb, nl);
      check($sformatf("%s vector %0d bus count", vtag[v], v), nb, VEC[v][3]);
      check($sformatf("%s vector %0d local count", vtag[v], v), nl, VEC[v][4]);
    end

    // R1: exact bus latency
    enterSleep(); tick(LR + 6);
    busLvl = 1'b0; tick(BF + 5);
    busLvl = 1'b1; c0 = cyc; tick(10);
    check("R1 bus pulse latency", busAt - c0, 3);

    // R5: exact local latency
    enterSleep(); tick(LR + 6);
    locLvl = 1'b0; c0 = cyc; tick(LF + 10);
    locLvl = 1'b1; tick(5);
    check("R5 local pulse latency", locAt - c0, LF + 3);

    // R9: same-cycle coincidence
    enterSleep(); tick(LR + 6);
    b0 = busTot; l0 = locTot; cb = 0;
    for (int c = 0; c < 60; c++) begin
      busLvl = !(c < BF + 1);
      locLvl = !(c >= 5 && c < 60);
      tick(1);
    end
    busLvl = 1'b1; locLvl = 1'b1; tick(10);
    check("R9 coincident bus count", busTot - b0, 1);
    check("R9 coincident local count", locTot - l0, 1);
    check("R9 same-cycle pulses", busAt - locAt, 0);

    // R2: short glitch then a qualifying run gives one request
    enterSleep(); tick(LR + 6);
    b0 = busTot;
    busLvl = 1'b0; tick(5); busLvl = 1'b1; tick(3);
    busLvl = 1'b0; tick(BF + 5); busLvl = 1'b1; tick(10);
    check("R2 restart after glitch", busTot - b0, 1);

    // R3: bus low at sleep entry
    b0 = busTot;
    sleepEn = 1'b0; busLvl = 1'b0; tick(4);
    sleepEn = 1'b1; tick(BF + 10);
    busLvl = 1'b1; tick(10);
    check("R3 no request without falling edge", busTot - b0, 0);

    // R8: run interrupted by leaving sleep
    enterSleep(); tick(LR + 6);
    b0 = busTot;
    busLvl = 1'b0; tick(10);
    sleepEn = 1'b0; tick(2); sleepEn = 1'b1;
    tick(BF + 10); busLvl = 1'b1; tick(10);
    check("R8 interrupted run discarded", busTot - b0, 0);

    // R8: nothing while awake
    b0 = busTot; l0 = locTot;
    sleepEn = 1'b0;
    busLvl = 1'b0; locLvl = 1'b0; tick(BF + LF + 10);
    busLvl = 1'b1; locLvl = 1'b1; tick(10);
    check("R8 awake bus quiet", busTot - b0, 0);
    check("R8 awake local quiet", locTot - l0, 0);

    // R7: local low at sleep entry, then re-arm boundary
    l0 = locTot;
    sleepEn = 1'b0; locLvl = 1'b0; tick(4);
    sleepEn = 1'b1; tick(LF + 20);
    check("R7 low at sleep entry ignored", locTot - l0, 0);
    locLvl = 1'b1; tick(LR);
    locLvl = 1'b0; tick(LF + 20);
    check("R7 high for re-arm time only ignored", locTot - l0, 0);
    locLvl = 1'b1; tick(LR + 1);
    locLvl = 1'b0; tick(LF + 20);
    check("R7 high past re-arm time accepted", locTot - l0, 1);
    locLvl = 1'b1; tick(LR);
    locLvl = 1'b0; tick(LF + 20);
    check("R7 re-arm needed after request", locTot - l0, 1);
    locLvl = 1'b1; tick(10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule